// File: doc/BRIEF.md
# Condition Flag Unit

This block keeps a file of single-bit condition flags. Each flag has its own index. Software-visible instructions write the flags one at a time, and nothing sets them implicitly as a side effect of arithmetic.

Each cycle the block accepts one operation. Three kinds of operation write a flag:

- **Compare.** Compares two 24-bit operand words, or a word against a constant, and writes the outcome to a named flag.
- **Boolean.** Combines two flags through one of eight two-input functions and writes the result to a named flag.
- **Bit pick.** Copies one bit of an index word or an arithmetic word into a named flag.

A fourth operation works the other way. It places a flag into a chosen bit of an index word and presents the modified word on an output. That operation writes no flag.

The whole flag vector is always visible. Two read ports let neighbouring logic look up single flags by index.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every flag is cleared. After reset, `flags_o` is zero and both read ports return 0.
- R2: Operation code 1 writes flag `dst_idx` with 1 when `word_a_i` is greater than or equal to the right-hand operand, treating both as 24-bit two's-complement numbers. Otherwise it writes 0.
- R3: Operation code 2 writes flag `dst_idx` with 1 when `word_a_i` equals the right-hand operand, and with 0 otherwise.
- R4: Operation code 3 writes flag `dst_idx` with 1 when `word_a_i` is greater than or equal to the right-hand operand, treating both as unsigned numbers.
- R5: The right-hand operand of a compare depends on `imm_en_i`. When it is 1, the operand is `imm_i` and `word_b_i` is ignored. When it is 0, the operand is `word_b_i`.
- R6: Operation code 4 writes flag `dst_idx` with f(a,b). Here a is flag `sa_idx` and b is flag `sb_idx`. `fn_i` selects f as follows:

  | `fn_i` | f |
  |---|---|
  | 0 | a AND b |
  | 1 | a OR b |
  | 2 | a XOR b |
  | 3 | a XNOR b |
  | 4 | a AND NOT b |
  | 5 | a OR NOT b |
  | 6 | NOR |
  | 7 | NAND |

- R7: Operation code 5 writes flag `dst_idx` with bit `bit_sel_i` of `word_a_i`. A bit index of 24 or more writes 0.
- R8: Operation code 6 writes flag `dst_idx` with bit `bit_sel_i` of the 48-bit `arith_i`.
- R9: `word_o` equals `word_a_i` with bit `bit_sel_i` replaced by flag `sa_idx`. This is combinational, in the same cycle. A bit index of 24 or more leaves the word unchanged. Operation code 7 selects this function and writes no flag.
- R10: A flag write takes effect at the rising edge where the operation is presented. It is visible on `flags_o` and on the read ports from the next cycle onward. It changes only flag `dst_idx`.
- R11: Operation code 0 leaves every flag unchanged, whatever the other inputs are.
- R12: A Boolean operation that reads a flag written by the operation in the cycle just before sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| fn_i | input | 3 | Boolean function select |
| dst_idx | input | 5 | Destination flag index |
| sa_idx | input | 5 | First source flag index |
| sb_idx | input | 5 | Second source flag index |
| word_a_i | input | 24 | Left compare operand / index word |
| word_b_i | input | 24 | Right compare operand |
| imm_en_i | input | 1 | Use constant as right compare operand |
| imm_i | input | 24 | Constant operand |
| arith_i | input | 48 | Arithmetic word for bit pick |
| bit_sel_i | input | 6 | Bit index for pick and place |
| rd_a_idx | input | 5 | Read port A index |
| rd_b_idx | input | 5 | Read port B index |
| flags_o | output | 32 | Whole flag vector |
| rd_a_o | output | 1 | Flag at read port A |
| rd_b_o | output | 1 | Flag at read port B |
| word_o | output | 24 | Index word with a flag placed in it |

## Verification
Every flag-writing operation has a latency of one edge. The bench drives an operation just after a falling edge. It reads the flags at the next falling edge, by which time the single register stage has captured the result.

The timing check looks a little before that edge as well. There the read port must still show the old value.

`word_o` has no register in its path. It is sampled one time unit after its inputs change, within the same cycle.

Back-to-back operations are issued on consecutive falling edges with no idle cycle between them. This confirms that the source read uses the value written one edge earlier.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    localparam int NFLAG_DEF = 32;
    localparam int IW_DEF    = 24;
    localparam int AW_DEF    = 48;
    localparam int NRD_DEF   = 4;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_CGE   = 3'd1,
        OP_CEQ   = 3'd2,
        OP_CUGE  = 3'd3,
        OP_BOOL  = 3'd4,
        OP_IPICK = 3'd5,
        OP_APICK = 3'd6,
        OP_PLACE = 3'd7
    } cfu_op_e;

    typedef enum logic [2:0] {
        FN_AND  = 3'd0,
        FN_OR   = 3'd1,
        FN_XOR  = 3'd2,
        FN_XNOR = 3'd3,
        FN_ANDN = 3'd4,
        FN_ORN  = 3'd5,
        FN_NOR  = 3'd6,
        FN_NAND = 3'd7
    } cfu_fn_e;

    typedef struct packed {
        logic eq;
        logic sge;
        logic uge;
    } cmp_res_t;

    typedef struct packed {
        logic we;
        logic val;
    } flag_wr_t;

    function automatic logic bool2(cfu_fn_e f, logic a, logic b);
        case (f)
            FN_AND:  return a & b;
            FN_OR:   return a | b;
            FN_XOR:  return a ^ b;
            FN_XNOR: return ~(a ^ b);
            FN_ANDN: return a & ~b;
            FN_ORN:  return a | ~b;
            FN_NOR:  return ~(a | b);
            default: return ~(a & b);
        endcase
    endfunction
endpackage

// File: rtl/cfu_compare.sv
module cfu_compare
    import cfu_pkg::*;
#(
    parameter int IW = IW_DEF
) (
    input  logic [IW-1:0] lhs_i,
    input  logic [IW-1:0] rhs_i,
    output cmp_res_t      res_o
);
    always_comb begin
        res_o.eq  = (lhs_i == rhs_i);
        res_o.sge = ($signed(lhs_i) >= $signed(rhs_i));
        res_o.uge = (lhs_i >= rhs_i);
    end

    // Equal operands satisfy both ordered relations.
    always_comb begin
        if (res_o.eq) begin
            p_eq_implies_ge_r3: assert (res_o.sge && res_o.uge);
        end
    end
endmodule

// File: rtl/cfu_bool.sv
module cfu_bool
    import cfu_pkg::*;
(
    input  logic [2:0] fn_i,
    input  logic       a_i,
    input  logic       b_i,
    output logic       y_o
);
    assign y_o = bool2(cfu_fn_e'(fn_i), a_i, b_i);
endmodule

// File: rtl/cfu_bit_pick.sv
module cfu_bit_pick #(
    parameter int W  = 24,
    parameter int SW = 6
) (
    input  logic [W-1:0]  word_i,
    input  logic [SW-1:0] sel_i,
    output logic          bit_o
);
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (sel_i == SW'(i)) bit_o = word_i[i];
        end
    end
endmodule

// File: rtl/cfu_bit_place.sv
module cfu_bit_place #(
    parameter int W  = 24,
    parameter int SW = 6
) (
    input  logic [W-1:0]  word_i,
    input  logic [SW-1:0] sel_i,
    input  logic          ins_i,
    output logic [W-1:0]  word_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign word_o[g] = (sel_i == SW'(g)) ? ins_i : word_i[g];
    end
endmodule

// File: rtl/cfu_flag_file.sv
module cfu_flag_file
    import cfu_pkg::*;
#(
    parameter int NFLAG = NFLAG_DEF,
    parameter int NRD   = NRD_DEF,
    localparam int FIW  = $clog2(NFLAG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  flag_wr_t                 wr_i,
    input  logic [FIW-1:0]           widx_i,
    input  logic [NRD-1:0][FIW-1:0]  rd_idx_i,
    output logic [NRD-1:0]           rd_val_o,
    output logic [NFLAG-1:0]         flags_o
);
    logic [NFLAG-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (wr_i.we) q[widx_i] <= wr_i.val;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_val_o[g] = q[rd_idx_i[g]];
    end

    assign flags_o = q;

    p_reset_clears_r1: assert property (@(posedge clk) rst |=> (q == '0));

    p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
        wr_i.we |=> (q[$past(widx_i)] == $past(wr_i.val)));

    p_single_change_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(q ^ $past(q)) <= 1));
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int NFLAG = NFLAG_DEF,
    parameter int IW    = IW_DEF,
    parameter int AW    = AW_DEF,
    localparam int FIW  = $clog2(NFLAG),
    localparam int BSW  = $clog2(AW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_i,
    input  logic [2:0]       fn_i,
    input  logic [FIW-1:0]   dst_idx,
    input  logic [FIW-1:0]   sa_idx,
    input  logic [FIW-1:0]   sb_idx,
    input  logic [IW-1:0]    word_a_i,
    input  logic [IW-1:0]    word_b_i,
    input  logic             imm_en_i,
    input  logic [IW-1:0]    imm_i,
    input  logic [AW-1:0]    arith_i,
    input  logic [BSW-1:0]   bit_sel_i,
    input  logic [FIW-1:0]   rd_a_idx,
    input  logic [FIW-1:0]   rd_b_idx,
    output logic [NFLAG-1:0] flags_o,
    output logic             rd_a_o,
    output logic             rd_b_o,
    output logic [IW-1:0]    word_o
);
    localparam int NRD = 4;

    cfu_op_e                  op;
    cmp_res_t                 cmp;
    flag_wr_t                 wr;
    logic [IW-1:0]            rhs;
    logic [NRD-1:0][FIW-1:0]  rd_idx;
    logic [NRD-1:0]           rd_val;
    logic                     bool_y;
    logic                     ipick;
    logic                     apick;

    assign op     = cfu_op_e'(op_i);
    assign rhs    = imm_en_i ? imm_i : word_b_i;
    // Ports 0 and 1 face outward; 2 and 3 feed the Boolean sources.
    assign rd_idx = {sb_idx, sa_idx, rd_b_idx, rd_a_idx};
    assign rd_a_o = rd_val[0];
    assign rd_b_o = rd_val[1];

    cfu_compare #(.IW(IW)) u_cmp (
        .lhs_i (word_a_i),
        .rhs_i (rhs),
        .res_o (cmp)
    );

    cfu_bool u_bool (
        .fn_i (fn_i),
        .a_i  (rd_val[2]),
        .b_i  (rd_val[3]),
        .y_o  (bool_y)
    );

    cfu_bit_pick #(.W(IW), .SW(BSW)) u_ipick (
        .word_i (word_a_i),
        .sel_i  (bit_sel_i),
        .bit_o  (ipick)
    );

    cfu_bit_pick #(.W(AW), .SW(BSW)) u_apick (
        .word_i (arith_i),
        .sel_i  (bit_sel_i),
        .bit_o  (apick)
    );

    cfu_bit_place #(.W(IW), .SW(BSW)) u_place (
        .word_i (word_a_i),
        .sel_i  (bit_sel_i),
        .ins_i  (rd_val[2]),
        .word_o (word_o)
    );

    always_comb begin
        wr = '{we: 1'b0, val: 1'b0};
        case (op)
            OP_CGE:   wr = '{we: 1'b1, val: cmp.sge};
            OP_CEQ:   wr = '{we: 1'b1, val: cmp.eq};
            OP_CUGE:  wr = '{we: 1'b1, val: cmp.uge};
            OP_BOOL:  wr = '{we: 1'b1, val: bool_y};
            OP_IPICK: wr = '{we: 1'b1, val: ipick};
            OP_APICK: wr = '{we: 1'b1, val: apick};
            default:  wr = '{we: 1'b0, val: 1'b0};
        endcase
    end

    cfu_flag_file #(.NFLAG(NFLAG), .NRD(NRD)) u_file (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr),
        .widx_i   (dst_idx),
        .rd_idx_i (rd_idx),
        .rd_val_o (rd_val),
        .flags_o  (flags_o)
    );

    // No-write operations keep the whole vector (R9 place, R11 idle).
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_NOP) || (op == OP_PLACE)) |=> $stable(flags_o));
endmodule

// File: tb/sim_cond_flag_unit.sv
module sim_cond_flag_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i, fn_i;
    logic [4:0]  dst_idx, sa_idx, sb_idx, rd_a_idx, rd_b_idx;
    logic [23:0] word_a_i, word_b_i, imm_i, word_o;
    logic        imm_en_i;
    logic [47:0] arith_i;
    logic [5:0]  bit_sel_i;
    logic [31:0] flags_o;
    logic        rd_a_o, rd_b_o;

    logic [31:0] exp_f;
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_flag_unit u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .fn_i(fn_i), .dst_idx(dst_idx),
        .sa_idx(sa_idx), .sb_idx(sb_idx), .word_a_i(word_a_i), .word_b_i(word_b_i),
        .imm_en_i(imm_en_i), .imm_i(imm_i), .arith_i(arith_i), .bit_sel_i(bit_sel_i),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .flags_o(flags_o),
        .rd_a_o(rd_a_o), .rd_b_o(rd_b_o), .word_o(word_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_fn(input logic [2:0] f, input logic a, input logic b);
        case (f)
            3'd0: return a && b;
            3'd1: return a || b;
            3'd2: return a != b;
            3'd3: return a == b;
            3'd4: return a && !b;
            3'd5: return a || !b;
            3'd6: return !(a || b);
            default: return !(a && b);
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        op_i = 3'd0; imm_en_i = 1'b0;
    endtask

    task automatic do_cmp(input logic [2:0] code, input logic [4:0] d, input logic [23:0] a,
                          input logic [23:0] b, input logic ie, input logic [23:0] iv,
                          input logic e, input string req);
        op_i = code; dst_idx = d; word_a_i = a; word_b_i = b; imm_en_i = ie; imm_i = iv;
        step(); idle();
        exp_f[d] = e;
        chk(req, 64'(flags_o[d]), 64'(e));
    endtask

    task automatic do_bool(input logic [2:0] f, input logic [4:0] d,
                           input logic [4:0] a, input logic [4:0] b);
        op_i = 3'd4; fn_i = f; dst_idx = d; sa_idx = a; sb_idx = b;
        step(); idle();
    endtask

    task automatic t_reset();
        rst = 1'b1; idle(); fn_i = '0; dst_idx = '0; sa_idx = '0; sb_idx = '0;
        word_a_i = '0; word_b_i = '0; imm_i = '0; arith_i = '0; bit_sel_i = '0;
        rd_a_idx = 5'd0; rd_b_idx = 5'd31;
        repeat (3) step();
        rst = 1'b0;
        exp_f = '0;
        chk("R1 flags", 64'(flags_o), 64'd0);
        chk("R1 read ports", 64'({rd_a_o, rd_b_o}), 64'd0);
    endtask

    task automatic t_compare();
        do_cmp(3'd1, 5'd3, 24'd5, 24'hFFFFFE, 1'b0, '0, 1'b1, "R2 5>=-2");
        do_cmp(3'd1, 5'd4, 24'hFFFFFB, 24'd3, 1'b0, '0, 1'b0, "R2 -5>=3");
        do_cmp(3'd1, 5'd4, 24'h800000, 24'h800000, 1'b0, '0, 1'b1, "R2 min>=min");
        do_cmp(3'd2, 5'd7, 24'h123456, 24'h123456, 1'b0, '0, 1'b1, "R3 eq");
        do_cmp(3'd2, 5'd7, 24'h123456, 24'h123457, 1'b0, '0, 1'b0, "R3 neq");
        do_cmp(3'd3, 5'd8, 24'd5, 24'hFFFFFE, 1'b0, '0, 1'b0, "R4 5 u>= big");
        do_cmp(3'd3, 5'd8, 24'hFFFFFE, 24'd5, 1'b0, '0, 1'b1, "R4 big u>= 5");
        do_cmp(3'd2, 5'd9, 24'd42, 24'd0, 1'b1, 24'd42, 1'b1, "R5 imm eq");
        do_cmp(3'd2, 5'd9, 24'd42, 24'd42, 1'b1, 24'd1, 1'b0, "R5 imm ignores word_b");
        chk("R10 others unchanged", 64'(flags_o), 64'(exp_f));
    endtask

    task automatic t_bool();
        // Flag 20 = 1, flag 21 = 0 as sources.
        do_cmp(3'd2, 5'd20, 24'd0, 24'd0, 1'b0, '0, 1'b1, "R3 setup");
        for (int f = 0; f < 8; f++) begin
            for (int p = 0; p < 4; p++) begin
                logic [4:0] a_ix = (p[1]) ? 5'd20 : 5'd21;
                logic [4:0] b_ix = (p[0]) ? 5'd20 : 5'd21;
                logic e = model_fn(3'(f), p[1], p[0]);
                do_bool(3'(f), 5'd30, a_ix, b_ix);
                exp_f[30] = e;
                chk($sformatf("R6 fn%0d a=%0d b=%0d", f, p[1], p[0]), 64'(flags_o[30]), 64'(e));
            end
        end
    endtask

    task automatic t_pick();
        op_i = 3'd5; dst_idx = 5'd13; word_a_i = 24'h800001; bit_sel_i = 6'd23;
        step(); idle(); exp_f[13] = 1'b1;
        chk("R7 bit 23", 64'(flags_o[13]), 64'd1);
        op_i = 3'd5; bit_sel_i = 6'd1;
        step(); idle(); exp_f[13] = 1'b0;
        chk("R7 bit 1", 64'(flags_o[13]), 64'd0);
        op_i = 3'd5; bit_sel_i = 6'd0;
        step(); idle(); exp_f[13] = 1'b1;
        op_i = 3'd5; word_a_i = 24'hFFFFFF; bit_sel_i = 6'd30;
        step(); idle(); exp_f[13] = 1'b0;
        chk("R7 out of range", 64'(flags_o[13]), 64'd0);
        op_i = 3'd6; dst_idx = 5'd12; arith_i = 48'h8000_0000_0001; bit_sel_i = 6'd47;
        step(); idle(); exp_f[12] = 1'b1;
        chk("R8 bit 47", 64'(flags_o[12]), 64'd1);
        op_i = 3'd6; bit_sel_i = 6'd46;
        step(); idle(); exp_f[12] = 1'b0;
        chk("R8 bit 46", 64'(flags_o[12]), 64'd0);
        chk("R10 vector", 64'(flags_o), 64'(exp_f));
    endtask

    task automatic t_place();
        op_i = 3'd7; dst_idx = 5'd2; sa_idx = 5'd20; word_a_i = 24'h000000; bit_sel_i = 6'd5;
        #1 chk("R9 place one", 64'(word_o), 64'h000020);
        sa_idx = 5'd21; word_a_i = 24'hFFFFFF; bit_sel_i = 6'd0;
        #1 chk("R9 place zero", 64'(word_o), 64'hFFFFFE);
        sa_idx = 5'd20; word_a_i = 24'h123456; bit_sel_i = 6'd30;
        #1 chk("R9 out of range", 64'(word_o), 64'h123456);
        step(); idle();
        chk("R9 no flag write", 64'(flags_o), 64'(exp_f));
    endtask

    task automatic t_timing_idle();
        rd_a_idx = 5'd25;
        op_i = 3'd2; dst_idx = 5'd25; word_a_i = 24'd9; word_b_i = 24'd9;
        #1 chk("R10 before edge", 64'(rd_a_o), 64'd0);
        step(); idle(); exp_f[25] = 1'b1;
        chk("R10 after edge", 64'(rd_a_o), 64'd1);
        op_i = 3'd0; dst_idx = 5'd25; fn_i = 3'd6; word_a_i = 24'd1; word_b_i = 24'd2;
        step();
        chk("R11 idle holds", 64'(flags_o), 64'(exp_f));
    endtask

    task automatic t_back_to_back();
        rd_b_idx = 5'd6;
        op_i = 3'd2; dst_idx = 5'd5; word_a_i = 24'd7; word_b_i = 24'd7;
        step();
        op_i = 3'd4; fn_i = 3'd0; dst_idx = 5'd6; sa_idx = 5'd5; sb_idx = 5'd5;
        step(); idle();
        exp_f[5] = 1'b1; exp_f[6] = 1'b1;
        chk("R12 dependent read", 64'(rd_b_o), 64'd1);
        chk("R12 vector", 64'(flags_o), 64'(exp_f));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_compare();
        t_bool();
        t_pick();
        t_place();
        t_timing_idle();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule